// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Tracker

This block sits between a memory controller's request logic and the command pins of a four-bank SDRAM. On every clock it decodes the requested command from chip select, row strobe, column strobe and write enable, together with the bank-select bits and the address. It keeps a small state machine and a set of cycle counters per bank. From these it decides whether the command may go out now.

A legal command passes to the output pins unchanged. An illegal command is replaced on the output pins by a NOP. In the same cycle, `legal_o` drops and a violation code shows which rule was broken. The controller treats a low `legal_o` as a stall and presents the command again later.

All timing limits are parameters counted in clock cycles:
- `T_RCD`: activate to column access.
- `T_RC`: activate to activate on the same bank.
- `T_RRD`: activate to activate on any two banks.
- `T_RAS_MAX`: maximum time a bank stays open.
- `T_AP`: how long an auto-precharge takes to close the bank.

Top module: `sdram_act_tracker`

## Requirements
- R1: Commands are decoded only while cs_n is low, from {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 111 NOP. ba_i selects the bank directly, with ba_i=0..3 meaning banks 0..3. A legal activate sets bank_open_o[ba_i] from the next cycle.
- R2: A read or write to a bank that is idle or auto-precharging is rejected with code 4.
- R3: A read or write to an open bank fewer than T_RCD cycles after its activate is rejected with code 5. At T_RCD cycles or more it is legal.
- R4: An activate to a bank whose bank_open_o bit is set is rejected with code 1.
- R5: An activate to an idle bank fewer than T_RC cycles after that bank's previous activate is rejected with code 2.
- R6: An activate fewer than T_RRD cycles after the last legal activate to any bank is rejected with code 3.
- R7: When several rules are broken at once, the reported code follows the order 1, then 2, then 3 for activates, and 4, then 5 for column commands.
- R8: A precharge with addr_i[10]=0 returns only the addressed bank to idle. With addr_i[10]=1 it returns every bank to idle. A precharge is always legal.
- R9: A legal read or write with addr_i[10]=1 keeps bank_open_o set for T_AP more cycles and then clears it. The T_RC limit still applies to the next activate of that bank.
- R10: tras_warn_o[b] is high while bank b is open and at least T_RAS_MAX cycles have passed since its activate. Otherwise it is low.
- R11: For a rejected command, the output pins carry a NOP (cs_n=0, ras_n=cas_n=we_n=1), legal_o is 0, viol_o is 1 and viol_code_o is nonzero, all in that cycle only. For a legal command, the pins are forwarded unchanged, legal_o is 1 and viol_code_o is 0.
- R12: After reset all banks are idle, no warning is raised and every counter is saturated, so the first command to any bank is legal.
- R13: Deselect (cs_n=1) and the remaining encodings (refresh, mode set, burst stop) are forwarded unchanged and are always legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Requested chip select, active low |
| ras_n_i | input | 1 | Requested row strobe, active low |
| cas_n_i | input | 1 | Requested column strobe, active low |
| we_n_i | input | 1 | Requested write enable, active low |
| ba_i | input | BA_W | Requested bank select |
| addr_i | input | ROW_W | Requested address; bit AP_BIT selects auto-precharge or precharge-all |
| cs_n_o | output | 1 | Chip select sent to the device |
| ras_n_o | output | 1 | Row strobe sent to the device |
| cas_n_o | output | 1 | Column strobe sent to the device |
| we_n_o | output | 1 | Write enable sent to the device |
| ba_o | output | BA_W | Bank select sent to the device |
| addr_o | output | ROW_W | Address sent to the device |
| legal_o | output | 1 | Requested command is legal this cycle; low means stall |
| viol_o | output | 1 | Requested command was rejected this cycle |
| viol_code_o | output | 3 | Rule broken: 0 none, 1 bank open, 2 T_RC, 3 T_RRD, 4 bank not open, 5 T_RCD |
| bank_open_o | output | NUM_BANKS | Per-bank open or auto-precharging flag |
| tras_warn_o | output | NUM_BANKS | Per-bank open-too-long warning |

## Verification
The hardest state to reach from the ports is a single activate that breaks two rules at once. One case is an open bank re-activated inside its T_RC window. The other is an idle bank whose T_RC window and the global T_RRD window are both still running, which needs an activate, a precharge, an activate to another bank and a second activate packed into four cycles. The auto-precharge close window is similarly narrow. The stimulus sweeps every ordered bank pair and every gap from one cycle up to past T_RC. It also sweeps activate-to-column gaps, and retries an activate on every cycle after an auto-precharge until one is accepted. A reference model in the bench predicts the code, pins and flags for every one of these cycles.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_ACT,
    OP_RD,
    OP_WR,
    OP_PRE,
    OP_OTHER
  } op_e;

  typedef enum logic [2:0] {
    VC_NONE     = 3'd0,
    VC_ACT_OPEN = 3'd1,
    VC_TRC      = 3'd2,
    VC_TRRD     = 3'd3,
    VC_COL_IDLE = 3'd4,
    VC_TRCD     = 3'd5
  } viol_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_CLOSING
  } bank_st_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output op_e  op_o
);

  always_comb begin
    if (cs_n_i) begin
      op_o = OP_NOP;
    end else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b111:  op_o = OP_NOP;
        3'b011:  op_o = OP_ACT;
        3'b101:  op_o = OP_RD;
        3'b100:  op_o = OP_WR;
        3'b010:  op_o = OP_PRE;
        default: op_o = OP_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer
  import sdram_trk_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RC      = 9,
  parameter int T_RAS_MAX = 40,
  parameter int T_AP      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic col_ap_i,
  input  logic pre_i,
  output logic busy_o,
  output logic open_o,
  output logic rcd_ok_o,
  output logic rc_ok_o,
  output logic tras_warn_o
);

  localparam int T_ACT_SAT = (T_RC > T_RCD) ? T_RC : T_RCD;
  localparam int CW        = $clog2(T_ACT_SAT + 1);
  localparam int OW        = $clog2(T_RAS_MAX + 1);
  localparam int AW        = (T_AP > 1) ? $clog2(T_AP) : 1;

  bank_st_e        st_q;
  logic [CW-1:0]   act_cnt_q;
  logic [OW-1:0]   open_cnt_q;
  logic [AW-1:0]   ap_cnt_q;

  // cycles since last activate, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             act_cnt_q <= CW'(T_ACT_SAT);
    else if (act_i)                          act_cnt_q <= CW'(1);
    else if (act_cnt_q != CW'(T_ACT_SAT))    act_cnt_q <= act_cnt_q + 1'b1;
  end

  // open time, saturating at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      open_cnt_q <= '0;
    else if (act_i)   open_cnt_q <= OW'(1);
    else if (st_q == BK_OPEN && open_cnt_q != OW'(T_RAS_MAX))
      open_cnt_q <= open_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= BK_IDLE;
      ap_cnt_q <= '0;
    end else begin
      case (st_q)
        BK_IDLE: if (act_i) st_q <= BK_OPEN;
        BK_OPEN: begin
          if (pre_i) begin
            st_q <= BK_IDLE;
          end else if (col_ap_i) begin
            st_q     <= BK_CLOSING;
            ap_cnt_q <= '0;
          end
        end
        BK_CLOSING: begin
          if (pre_i || ap_cnt_q == AW'(T_AP - 1)) st_q <= BK_IDLE;
          else                                    ap_cnt_q <= ap_cnt_q + 1'b1;
        end
        default: st_q <= BK_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != BK_IDLE);
  assign open_o      = (st_q == BK_OPEN);
  assign rcd_ok_o    = (act_cnt_q >= CW'(T_RCD));
  assign rc_ok_o     = (act_cnt_q >= CW'(T_RC));
  assign tras_warn_o = open_o && (open_cnt_q == OW'(T_RAS_MAX));

endmodule

// File: rtl/sdram_act_tracker.sv
module sdram_act_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_RAS_MAX = 40,
  parameter int T_AP      = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ROW_W-1:0]     addr_i,
  output logic                 cs_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic [BA_W-1:0]      ba_o,
  output logic [ROW_W-1:0]     addr_o,
  output logic                 legal_o,
  output logic                 viol_o,
  output logic [2:0]           viol_code_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic [NUM_BANKS-1:0] tras_warn_o
);

  localparam int RW = $clog2(T_RRD + 1);

  op_e                  op;
  viol_e                code;
  logic                 legal;
  logic                 is_col;
  logic                 ap_bit;
  logic [RW-1:0]        rrd_cnt_q;
  logic                 rrd_ok;
  logic [NUM_BANKS-1:0] busy, opened, rcd_ok, rc_ok, warn;

  sdram_cmd_decode u_dec (
    .cs_n_i (cs_n_i),
    .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i),
    .we_n_i (we_n_i),
    .op_o   (op)
  );

  assign is_col = (op == OP_RD) || (op == OP_WR);
  assign ap_bit = addr_i[AP_BIT];

  always_comb begin
    code = VC_NONE;
    if (op == OP_ACT) begin
      if (busy[ba_i])        code = VC_ACT_OPEN;
      else if (!rc_ok[ba_i]) code = VC_TRC;
      else if (!rrd_ok)      code = VC_TRRD;
    end else if (is_col) begin
      if (!opened[ba_i])      code = VC_COL_IDLE;
      else if (!rcd_ok[ba_i]) code = VC_TRCD;
    end
  end

  assign legal = (code == VC_NONE);

  // spacing between activates on any banks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           rrd_cnt_q <= RW'(T_RRD);
    else if (legal && op == OP_ACT)        rrd_cnt_q <= RW'(1);
    else if (rrd_cnt_q != RW'(T_RRD))      rrd_cnt_q <= rrd_cnt_q + 1'b1;
  end
  assign rrd_ok = (rrd_cnt_q >= RW'(T_RRD));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (ba_i == BA_W'(b));

    sdram_bank_timer #(
      .T_RCD    (T_RCD),
      .T_RC     (T_RC),
      .T_RAS_MAX(T_RAS_MAX),
      .T_AP     (T_AP)
    ) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (legal && op == OP_ACT && sel),
      .col_ap_i   (legal && is_col && ap_bit && sel),
      .pre_i      (op == OP_PRE && (ap_bit || sel)),
      .busy_o     (busy[b]),
      .open_o     (opened[b]),
      .rcd_ok_o   (rcd_ok[b]),
      .rc_ok_o    (rc_ok[b]),
      .tras_warn_o(warn[b])
    );
  end

  assign cs_n_o      = legal ? cs_n_i  : 1'b0;
  assign ras_n_o     = legal ? ras_n_i : 1'b1;
  assign cas_n_o     = legal ? cas_n_i : 1'b1;
  assign we_n_o      = legal ? we_n_i  : 1'b1;
  assign ba_o        = ba_i;
  assign addr_o      = addr_i;
  assign legal_o     = legal;
  assign viol_o      = !legal;
  assign viol_code_o = code;
  assign bank_open_o = busy;
  assign tras_warn_o = warn;

endmodule

// File: rtl/sdram_act_tracker_chk.sv
module sdram_act_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int T_RRD     = 2,
  parameter int BA_W      = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_n_o,
  input logic                 ras_n_o,
  input logic                 cas_n_o,
  input logic                 we_n_o,
  input logic [BA_W-1:0]      ba_o,
  input logic                 ap_o,
  input logic                 viol_o,
  input logic [2:0]           viol_code_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic [NUM_BANKS-1:0] tras_warn_o
);

  localparam int RW = $clog2(T_RRD + 1);

  logic fwd_act, fwd_col, fwd_pre;
  logic [RW-1:0] gap_q;

  assign fwd_act = !cs_n_o && !ras_n_o &&  cas_n_o &&  we_n_o;
  assign fwd_col = !cs_n_o &&  ras_n_o && !cas_n_o;
  assign fwd_pre = !cs_n_o && !ras_n_o &&  cas_n_o && !we_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    gap_q <= RW'(T_RRD);
    else if (fwd_act)               gap_q <= RW'(1);
    else if (gap_q != RW'(T_RRD))   gap_q <= gap_q + 1'b1;
  end

  p_nop_sub_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (!cs_n_o && ras_n_o && cas_n_o && we_n_o));

  p_code_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o == (viol_code_o != 3'd0));

  p_rrd_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_act |-> gap_q >= RW'(T_RRD));

  p_pre_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_pre && ap_o) |=> bank_open_o == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    p_act_opens_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_act && ba_o == BA_W'(b)) |=> bank_open_o[b]);

    p_act_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_act && ba_o == BA_W'(b)) |-> !bank_open_o[b]);

    p_col_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_col && ba_o == BA_W'(b)) |-> bank_open_o[b]);

    p_warn_open_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tras_warn_o[b] |-> bank_open_o[b]);
  end

endmodule

bind sdram_act_tracker sdram_act_tracker_chk #(
  .NUM_BANKS(NUM_BANKS),
  .T_RRD    (T_RRD),
  .BA_W     (BA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_o     (cs_n_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .ba_o       (ba_o),
  .ap_o       (addr_o[AP_BIT]),
  .viol_o     (viol_o),
  .viol_code_o(viol_code_o),
  .bank_open_o(bank_open_o),
  .tras_warn_o(tras_warn_o)
);

// File: tb/sim_sdram_act_tracker.sv
`timescale 1ns/1ps
module sim_sdram_act_tracker;

  localparam int NB = 4, RWID = 12, APB = 10;
  localparam int T_RCD = 3, T_RC = 9, T_RRD = 2, T_RAS_MAX = 40, T_AP = 2;
  localparam int O_NOP = 0, O_ACT = 1, O_RD = 2, O_WR = 3, O_PRE = 4, O_REF = 5, O_DES = 6;

  logic clk = 0, rst_ni = 0;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [RWID-1:0] addr;
  logic cs_n_o, ras_n_o, cas_n_o, we_n_o, legal_o, viol_o;
  logic [1:0] ba_o;
  logic [RWID-1:0] addr_o;
  logic [2:0] viol_code_o;
  logic [NB-1:0] bank_open_o, tras_warn_o;

  always #4 clk = ~clk;

  sdram_act_tracker #(
    .NUM_BANKS(NB), .ROW_W(RWID), .AP_BIT(APB), .T_RCD(T_RCD), .T_RC(T_RC),
    .T_RRD(T_RRD), .T_RAS_MAX(T_RAS_MAX), .T_AP(T_AP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .ba_i(ba), .addr_i(addr), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o),
    .legal_o(legal_o), .viol_o(viol_o), .viol_code_o(viol_code_o),
    .bank_open_o(bank_open_o), .tras_warn_o(tras_warn_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0, last_any = -1000, last_code = 0;
  int last_act[NB], ap_at[NB], st[NB];

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic resolve();
    for (int b = 0; b < NB; b++)
      if (st[b] == 2 && cyc - ap_at[b] > T_AP) st[b] = 0;
  endtask

  function automatic int exp_code(input int op, input int b);
    if (op == O_ACT) begin
      if (st[b] != 0)                 return 1;
      if (cyc - last_act[b] < T_RC)   return 2;
      if (cyc - last_any < T_RRD)     return 3;
    end else if (op == O_RD || op == O_WR) begin
      if (st[b] != 1)                 return 4;
      if (cyc - last_act[b] < T_RCD)  return 5;
    end
    return 0;
  endfunction

  task automatic drive(input int op, input int b, input bit a10);
    logic [3:0] pins;
    int e, om, wm;
    string tag;
    @(negedge clk);
    case (op)
      O_ACT:   pins = 4'b0011;
      O_RD:    pins = 4'b0101;
      O_WR:    pins = 4'b0100;
      O_PRE:   pins = 4'b0010;
      O_REF:   pins = 4'b0001;
      O_DES:   pins = 4'b1000;
      default: pins = 4'b0111;
    endcase
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba = 2'(b);
    addr = RWID'(b * 37 + 5);
    addr[APB] = a10;
    #1;
    resolve();
    e = exp_code(op, b);
    last_code = e;
    case (e)
      1: tag = "R4";
      2: tag = "R5";
      3: tag = "R6";
      4: tag = "R2";
      5: tag = "R3";
      default: tag = (op == O_ACT) ? "R1" : (op == O_RD || op == O_WR) ? "R3" :
                     (op == O_PRE) ? "R8" : "R13";
    endcase
    chk(tag, int'(viol_code_o), e);
    chk("R11", int'(legal_o), int'(e == 0));
    chk("R11", int'(viol_o), int'(e != 0));
    if (e != 0) chk("R11", int'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 4'b0111);
    else        chk("R11", int'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), int'(pins));
    chk("R1", int'(ba_o), b);
    om = 0; wm = 0;
    for (int k = 0; k < NB; k++) begin
      if (st[k] != 0) om |= (1 << k);
      if (st[k] == 1 && cyc - last_act[k] >= T_RAS_MAX) wm |= (1 << k);
    end
    chk("R1", int'(bank_open_o), om);
    chk("R10", int'(tras_warn_o), wm);
    @(posedge clk);
    if (e == 0) begin
      if (op == O_ACT) begin
        st[b] = 1; last_act[b] = cyc; last_any = cyc;
      end else if ((op == O_RD || op == O_WR) && a10) begin
        st[b] = 2; ap_at[b] = cyc;
      end else if (op == O_PRE) begin
        if (a10) for (int k = 0; k < NB; k++) st[k] = 0;
        else st[b] = 0;
      end
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(O_NOP, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int b = 0; b < NB; b++) begin last_act[b] = -1000; ap_at[b] = -1000; st[b] = 0; end
    {cs_n, ras_n, cas_n, we_n} = 4'b0111; ba = 0; addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1;
    #1;
    // R12: reset state
    chk("R12", int'(bank_open_o), 0);
    chk("R12", int'(tras_warn_o), 0);
    chk("R12", int'(legal_o), 1);
    drive(O_ACT, 3, 0);
    chk("R12", last_code, 0);
    drive(O_PRE, 0, 1);
    idle(T_RC);

    // R4/R6: every bank pair and gap
    for (int a = 0; a < NB; a++)
      for (int b = 0; b < NB; b++)
        for (int g = 1; g <= T_RC + 1; g++) begin
          drive(O_ACT, a, 0);
          idle(g - 1);
          drive(O_ACT, b, 0);
          if (a == b && g < T_RC) chk("R7", last_code, 1);
          drive(O_PRE, 0, 1);
          idle(T_RC);
        end

    // R5: same bank after precharge
    for (int b = 0; b < NB; b++)
      for (int g = 2; g <= T_RC + 1; g++) begin
        drive(O_ACT, b, 0);
        drive(O_PRE, b, 0);
        idle(g - 2);
        drive(O_ACT, b, 0);
        drive(O_PRE, b, 0);
        idle(T_RC);
      end

    // R3: activate to column gap
    for (int b = 0; b < NB; b++)
      for (int g = 1; g <= T_RCD + 1; g++) begin
        drive(O_ACT, b, 0);
        idle(g - 1);
        drive(O_RD, b, 0);
        drive(O_WR, b, 0);
        drive(O_PRE, b, 0);
        idle(T_RC);
      end

    // R2: column to idle bank
    for (int b = 0; b < NB; b++) begin
      drive(O_WR, b, 0);
      chk("R2", last_code, 4);
    end

    // R7: T_RC and T_RRD broken together
    drive(O_ACT, 0, 0);
    drive(O_PRE, 0, 0);
    drive(O_ACT, 1, 0);
    drive(O_ACT, 0, 0);
    chk("R7", last_code, 2);
    drive(O_PRE, 0, 1);
    idle(T_RC);

    // R9: auto-precharge, then retry activate each cycle
    for (int b = 0; b < NB; b++) begin
      drive(O_ACT, b, 0);
      idle(T_RCD - 1);
      drive(b[0] ? O_RD : O_WR, b, 1);
      chk("R9", last_code, 0);
      drive(O_RD, b, 0);
      chk("R9", last_code, 4);
      for (int i = 0; i < 20; i++) begin
        drive(O_ACT, b, 0);
        if (last_code == 0) break;
      end
      chk("R9", last_code, 0);
      drive(O_PRE, b, 0);
      idle(T_RC);
    end

    // R8: single and all-bank precharge
    drive(O_ACT, 0, 0); idle(1);
    drive(O_ACT, 1, 0); idle(1);
    drive(O_ACT, 2, 0); idle(1);
    drive(O_PRE, 1, 0);
    idle(1);
    chk("R8", int'(bank_open_o), 4'b0101);
    drive(O_PRE, 3, 1);
    idle(1);
    chk("R8", int'(bank_open_o), 0);
    idle(T_RC);

    // R10: open-time warning
    drive(O_ACT, 2, 0);
    idle(T_RAS_MAX + 5);
    chk("R10", int'(tras_warn_o), 4'b0100);
    drive(O_PRE, 2, 0);
    idle(2);

    // R13: other encodings pass
    drive(O_REF, 1, 0);
    drive(O_DES, 2, 0);
    drive(O_NOP, 3, 1);
    chk("R13", int'(legal_o), 1);

    finish_run();
  end

endmodule